// File: doc/BRIEF.md
# Display Register Front End with Read-Unlocked Colour-Mode Register

This block is the byte-wide, address-decoded register front end of a display controller. It holds three banks of configuration registers: a sequencer bank, a CRT controller bank and a graphics controller bank. Each bank is reached through an index/data pair. Software writes a register number to the bank's index port. It then reads or writes that register through the bank's data port. The contents of every bank are driven out in flattened form to the rest of the display pipeline.

A fourth port holds the pixel mask. It also guards a hidden colour-mode register. A small state machine counts reads of the mask port that follow one another without any other access in between. The states are `UL_IDLE`, `UL_SEEN1`, `UL_SEEN2`, `UL_SEEN3` and `UL_ARMED`.

The state machine has these transitions:
- A mask-port read advances `UL_IDLE`→`UL_SEEN1`→`UL_SEEN2`→`UL_SEEN3`→`UL_ARMED`.
- A mask-port read in `UL_ARMED` stays in `UL_ARMED`.
- A mask-port write returns to `UL_IDLE` from any state.
- An access to any other port returns to `UL_IDLE` from any state.
- Idle bus cycles leave the state unchanged.

A write that arrives in `UL_ARMED` lands in the colour-mode register. A write in any other state lands in the pixel mask.

The block also decodes the pixel-format field of sequencer register 7 into a bits-per-pixel value.

A cycle with `bus_wr` high is a write. A cycle with `bus_rd` high and `bus_wr` low is a read. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. It holds there until the next read.

Top module: `dispreg_frontend`

## Requirements
- R1: After reset, every bank register, every index, the pixel mask, the colour-mode register, `bus_rdata` and `pix_bpp_o` are zero.
- R2: Byte offset 4 is the sequencer index port and offset 5 its data port. A write to offset 5 stores into the register selected by the index. A read of offset 5 returns that register on `bus_rdata` one cycle after the read strobe. Sequencer register k appears on `seq_regs_o[8k+7:8k]`.
- R3: Offset 0x14 is the CRT controller index port and 0x15 its data port, with the same behaviour as R2 on `crt_regs_o`.
- R4: Offset 0x0E is the graphics controller index port and 0x0F its data port, with the same behaviour as R2 on `gfx_regs_o`.
- R5: A data write while a bank's index is at or above that bank's register count changes no register. A data read at such an index returns 0x00.
- R6: A mask-port write made after four consecutive mask-port reads goes to the colour-mode register and leaves the pixel mask unchanged.
- R7: The mask port is at offset 0x06. A write there in any state other than `UL_ARMED` updates the pixel mask and leaves the colour-mode register unchanged. A read of it returns the pixel mask.
- R8: An access to any offset other than 0x06 returns the counter to `UL_IDLE`, so the reads before it do not count.
- R9: Reads beyond the fourth keep the counter armed. Any mask-port write returns it to `UL_IDLE`, so the write after a colour-mode write goes to the pixel mask.
- R10: `pix_bpp_o` decodes the low five bits of sequencer register 7, ignoring its upper three bits: 0x11 gives 8, 0x17 gives 16, 0x15 gives 24, 0x19 gives 32, and any other value gives 0.
- R11: A read of an index port returns the index last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access; wins over bus_rd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| seq_regs_o | output | 8*SEQ_N | Flattened sequencer bank |
| crt_regs_o | output | 8*CRT_N | Flattened CRT controller bank |
| gfx_regs_o | output | 8*GFX_N | Flattened graphics controller bank |
| pix_mask_o | output | 8 | Pixel mask register |
| colour_mode_o | output | 8 | Hidden colour-mode register |
| pix_bpp_o | output | 6 | Decoded bits per pixel (0, 8, 16, 24 or 32) |

## Verification
The bench builds the block with SEQ_N=8, CRT_N=28 and GFX_N=16. With these values, out-of-range indices are easy to reach: sequencer index 9 and CRT index 0x1C. They also leave sequencer register 7 in the bank, so the pixel-format decode is live. The unlock sequences cover these cases:
- three reads then a write;
- exactly four reads then a write;
- six reads then a write;
- runs broken by a read of another port;
- runs broken by a write to another port.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

    localparam int OFS_SEQ_IDX = 4;
    localparam int OFS_SEQ_DAT = 5;
    localparam int OFS_MASK    = 6;
    localparam int OFS_GFX_IDX = 14;
    localparam int OFS_GFX_DAT = 15;
    localparam int OFS_CRT_IDX = 20;
    localparam int OFS_CRT_DAT = 21;

    localparam int PIXFMT_REG  = 7;

    typedef enum logic [2:0] {
        UL_IDLE,
        UL_SEEN1,
        UL_SEEN2,
        UL_SEEN3,
        UL_ARMED
    } unlock_e;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_SEQ_I,
        PORT_SEQ_D,
        PORT_CRT_I,
        PORT_CRT_D,
        PORT_GFX_I,
        PORT_GFX_D,
        PORT_MASK
    } port_e;

    function automatic port_e decode_port(input int unsigned ofs);
        port_e p;
        p = PORT_NONE;
        unique case (ofs)
            OFS_SEQ_IDX: p = PORT_SEQ_I;
            OFS_SEQ_DAT: p = PORT_SEQ_D;
            OFS_CRT_IDX: p = PORT_CRT_I;
            OFS_CRT_DAT: p = PORT_CRT_D;
            OFS_GFX_IDX: p = PORT_GFX_I;
            OFS_GFX_DAT: p = PORT_GFX_D;
            OFS_MASK:    p = PORT_MASK;
            default:     p = PORT_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dispreg_bank.sv
module dispreg_bank #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idx_we,
    input  logic           dat_we,
    input  logic [7:0]     wdata,
    output logic [7:0]     idx_q,
    output logic [7:0]     rd_val,
    output logic [N*8-1:0] flat_q
);
    localparam int NREG = (N > 256) ? 256 : N;

    logic [7:0] regs [NREG];

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata;
        end
    end

    // one storage byte per implemented register
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (dat_we && (idx_q == 8'(i))) begin
                regs[i] <= wdata;
            end
        end
        assign flat_q[i*8 +: 8] = regs[i];
    end

    if (N > NREG) begin : g_pad
        assign flat_q[N*8-1:NREG*8] = '0;
    end

    // selected register, zero outside the implemented range
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx_q == 8'(i)) begin
                rd_val = regs[i];
            end
        end
    end

endmodule

// File: rtl/dispreg_unlock.sv
module dispreg_unlock
    import dispreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_rd,
    input  logic mask_wr,
    input  logic other_acc,
    output logic armed
);
    unlock_e state_q;
    unlock_e state_d;

    // next state
    always_comb begin
        state_d = state_q;
        if (other_acc || mask_wr) begin
            state_d = UL_IDLE;
        end else if (mask_rd) begin
            unique case (state_q)
                UL_IDLE:  state_d = UL_SEEN1;
                UL_SEEN1: state_d = UL_SEEN2;
                UL_SEEN2: state_d = UL_SEEN3;
                UL_SEEN3: state_d = UL_ARMED;
                UL_ARMED: state_d = UL_ARMED;
                default:  state_d = UL_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            UL_ARMED: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

endmodule

// File: rtl/dispreg_frontend.sv
module dispreg_frontend
    import dispreg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SEQ_N  = 8,
    parameter int CRT_N  = 32,
    parameter int GFX_N  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [SEQ_N*8-1:0] seq_regs_o,
    output logic [CRT_N*8-1:0] crt_regs_o,
    output logic [GFX_N*8-1:0] gfx_regs_o,
    output logic [7:0]         pix_mask_o,
    output logic [7:0]         colour_mode_o,
    output logic [5:0]         pix_bpp_o
);
    port_e      port;
    logic       acc_rd;
    logic       acc_wr;
    logic       armed;
    logic [7:0] seq_idx, crt_idx, gfx_idx;
    logic [7:0] seq_rd, crt_rd, gfx_rd;
    logic [7:0] rd_mux;

    assign port   = decode_port(int'(bus_addr));
    assign acc_wr = bus_wr;
    assign acc_rd = bus_rd & ~bus_wr;

    dispreg_bank #(.N(SEQ_N)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (acc_wr && port == PORT_SEQ_I),
        .dat_we (acc_wr && port == PORT_SEQ_D),
        .wdata  (bus_wdata),
        .idx_q  (seq_idx),
        .rd_val (seq_rd),
        .flat_q (seq_regs_o)
    );

    dispreg_bank #(.N(CRT_N)) u_crt (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (acc_wr && port == PORT_CRT_I),
        .dat_we (acc_wr && port == PORT_CRT_D),
        .wdata  (bus_wdata),
        .idx_q  (crt_idx),
        .rd_val (crt_rd),
        .flat_q (crt_regs_o)
    );

    dispreg_bank #(.N(GFX_N)) u_gfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (acc_wr && port == PORT_GFX_I),
        .dat_we (acc_wr && port == PORT_GFX_D),
        .wdata  (bus_wdata),
        .idx_q  (gfx_idx),
        .rd_val (gfx_rd),
        .flat_q (gfx_regs_o)
    );

    dispreg_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_rd   (acc_rd && port == PORT_MASK),
        .mask_wr   (acc_wr && port == PORT_MASK),
        .other_acc ((acc_rd || acc_wr) && port != PORT_MASK),
        .armed     (armed)
    );

    // mask and hidden colour-mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_mask_o    <= '0;
            colour_mode_o <= '0;
        end else if (acc_wr && port == PORT_MASK) begin
            if (armed) begin
                colour_mode_o <= bus_wdata;
            end else begin
                pix_mask_o <= bus_wdata;
            end
        end
    end

    // read mux
    always_comb begin
        unique case (port)
            PORT_SEQ_I: rd_mux = seq_idx;
            PORT_SEQ_D: rd_mux = seq_rd;
            PORT_CRT_I: rd_mux = crt_idx;
            PORT_CRT_D: rd_mux = crt_rd;
            PORT_GFX_I: rd_mux = gfx_idx;
            PORT_GFX_D: rd_mux = gfx_rd;
            PORT_MASK:  rd_mux = pix_mask_o;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // pixel-format decode of sequencer register 7
    if (SEQ_N > PIXFMT_REG) begin : g_bpp
        logic [4:0] fmt_sel;
        assign fmt_sel = seq_regs_o[PIXFMT_REG*8 +: 5];
        always_comb begin
            unique case (fmt_sel)
                5'h11:   pix_bpp_o = 6'd8;
                5'h17:   pix_bpp_o = 6'd16;
                5'h15:   pix_bpp_o = 6'd24;
                5'h19:   pix_bpp_o = 6'd32;
                default: pix_bpp_o = 6'd0;
            endcase
        end
    end else begin : g_no_bpp
        assign pix_bpp_o = 6'd0;
    end

endmodule

// File: rtl/dispreg_frontend_chk.sv
module dispreg_frontend_chk #(
    parameter int ADDR_W = 5,
    parameter int SEQ_N  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [SEQ_N*8-1:0] seq_regs_o,
    input logic [7:0]         pix_mask_o,
    input logic [7:0]         colour_mode_o,
    input logic [7:0]         seq_idx,
    input logic               armed
);
    logic mask_hit, seq_dat_hit;
    assign mask_hit    = (int'(bus_addr) == 6);
    assign seq_dat_hit = (int'(bus_addr) == 5);

    a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mask_hit && !armed) |=>
            (pix_mask_o == $past(bus_wdata)) && $stable(colour_mode_o));

    a_r6_hidden_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mask_hit && armed) |=>
            (colour_mode_o == $past(bus_wdata)) && $stable(pix_mask_o));

    a_r8_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !mask_hit) |=> !armed);

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_rd && !bus_wr && mask_hit) |=> armed);

    a_r9_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mask_hit) |=> !armed);

    a_r5_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && seq_dat_hit && (int'(seq_idx) >= SEQ_N)) |=> $stable(seq_regs_o));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind dispreg_frontend dispreg_frontend_chk #(
    .ADDR_W (ADDR_W),
    .SEQ_N  (SEQ_N)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .seq_regs_o    (seq_regs_o),
    .pix_mask_o    (pix_mask_o),
    .colour_mode_o (colour_mode_o),
    .seq_idx       (seq_idx),
    .armed         (armed)
);

// File: tb/dispreg_frontend_test.sv
module dispreg_frontend_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int SEQ_N  = 8;
    localparam int CRT_N  = 28;
    localparam int GFX_N  = 16;

    localparam logic [4:0] A_SEQ_I = 5'h04, A_SEQ_D = 5'h05, A_MASK = 5'h06;
    localparam logic [4:0] A_GFX_I = 5'h0E, A_GFX_D = 5'h0F;
    localparam logic [4:0] A_CRT_I = 5'h14, A_CRT_D = 5'h15;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_rd = 1'b0;
    logic               bus_wr = 1'b0;
    logic [7:0]         bus_wdata = '0;
    logic [7:0]         bus_rdata;
    logic [SEQ_N*8-1:0] seq_regs_o;
    logic [CRT_N*8-1:0] crt_regs_o;
    logic [GFX_N*8-1:0] gfx_regs_o;
    logic [7:0]         pix_mask_o;
    logic [7:0]         colour_mode_o;
    logic [5:0]         pix_bpp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] q_exp [$];
    string      q_tag [$];
    logic       rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispreg_frontend #(
        .ADDR_W (ADDR_W),
        .SEQ_N  (SEQ_N),
        .CRT_N  (CRT_N),
        .GFX_N  (GFX_N)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .seq_regs_o    (seq_regs_o),
        .crt_regs_o    (crt_regs_o),
        .gfx_regs_o    (gfx_regs_o),
        .pix_mask_o    (pix_mask_o),
        .colour_mode_o (colour_mode_o),
        .pix_bpp_o     (pix_bpp_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: read data lands one cycle after the strobe
    always @(posedge clk) rd_seen <= bus_rd & ~bus_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_exp.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: read data %0h with nothing expected", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic drive(input logic [4:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_rd    = r;
        bus_wr    = w;
        bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        drive(a, 1'b0, 1'b1, d);
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        drive(a, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic mask_reads(input int n, input logic [7:0] exp, input string tag);
        for (int i = 0; i < n; i++) rd(A_MASK, exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 seq", 64'(seq_regs_o), 64'h0);
        check("R1 crt", 64'(crt_regs_o[63:0]), 64'h0);
        check("R1 gfx", 64'(gfx_regs_o[63:0]), 64'h0);
        check("R1 mask", 64'(pix_mask_o), 64'h0);
        check("R1 colour", 64'(colour_mode_o), 64'h0);
        check("R1 bpp", 64'(pix_bpp_o), 64'h0);
        check("R1 rdata", 64'(bus_rdata), 64'h0);
        rd(A_SEQ_D, 8'h00, "R1 seq reg0 read");

        // R2 sequencer bank, R11 index readback
        wr(A_SEQ_I, 8'h02);
        wr(A_SEQ_D, 8'hA5);
        rd(A_SEQ_I, 8'h02, "R11 seq index");
        rd(A_SEQ_D, 8'hA5, "R2 seq data");
        check("R2 seq flat", 64'(seq_regs_o[23:16]), 64'hA5);

        // R10 pixel-format decode
        wr(A_SEQ_I, 8'h07);
        wr(A_SEQ_D, 8'hF1);
        check("R10 8bpp", 64'(pix_bpp_o), 64'd8);
        wr(A_SEQ_D, 8'h17);
        check("R10 16bpp", 64'(pix_bpp_o), 64'd16);
        wr(A_SEQ_D, 8'hB5);
        check("R10 24bpp", 64'(pix_bpp_o), 64'd24);
        wr(A_SEQ_D, 8'h79);
        check("R10 32bpp", 64'(pix_bpp_o), 64'd32);
        wr(A_SEQ_D, 8'h1F);
        check("R10 other", 64'(pix_bpp_o), 64'd0);

        // R3 CRT bank
        wr(A_CRT_I, 8'h13);
        wr(A_CRT_D, 8'h5C);
        rd(A_CRT_I, 8'h13, "R11 crt index");
        rd(A_CRT_D, 8'h5C, "R3 crt data");
        check("R3 crt flat", 64'(crt_regs_o[8*19 +: 8]), 64'h5C);

        // R4 graphics bank
        wr(A_GFX_I, 8'h05);
        wr(A_GFX_D, 8'h40);
        rd(A_GFX_D, 8'h40, "R4 gfx data");
        check("R4 gfx flat", 64'(gfx_regs_o[8*5 +: 8]), 64'h40);

        // R5 out-of-range indices
        wr(A_SEQ_I, 8'h09);
        wr(A_SEQ_D, 8'h77);
        check("R5 seq untouched", 64'(seq_regs_o), {8'h1F, 32'h0, 8'hA5, 16'h0});
        rd(A_SEQ_D, 8'h00, "R5 seq oor read");
        wr(A_CRT_I, 8'h1C);
        wr(A_CRT_D, 8'h33);
        rd(A_CRT_D, 8'h00, "R5 crt oor read");
        check("R5 crt untouched", 64'(crt_regs_o[8*19 +: 8]), 64'h5C);

        // R7 mask writes while not armed
        wr(A_MASK, 8'hFF);
        check("R7 mask", 64'(pix_mask_o), 64'hFF);
        mask_reads(3, 8'hFF, "R7 mask read");
        wr(A_MASK, 8'h3C);
        check("R7 mask after 3 reads", 64'(pix_mask_o), 64'h3C);
        check("R7 colour unchanged", 64'(colour_mode_o), 64'h00);

        // R6 four reads arm the hidden register
        mask_reads(4, 8'h3C, "R6 mask read");
        wr(A_MASK, 8'hC1);
        check("R6 colour", 64'(colour_mode_o), 64'hC1);
        check("R6 mask kept", 64'(pix_mask_o), 64'h3C);

        // R9 write disarms; saturation beyond four
        wr(A_MASK, 8'h0F);
        check("R9 mask after hidden write", 64'(pix_mask_o), 64'h0F);
        check("R9 colour kept", 64'(colour_mode_o), 64'hC1);
        mask_reads(6, 8'h0F, "R9 mask read");
        wr(A_MASK, 8'hC5);
        check("R9 colour after 6 reads", 64'(colour_mode_o), 64'hC5);
        check("R9 mask kept", 64'(pix_mask_o), 64'h0F);

        // R8 other-port read breaks the run
        mask_reads(3, 8'h0F, "R8 mask read");
        rd(A_GFX_D, 8'h40, "R8 gfx read");
        rd(A_MASK, 8'h0F, "R8 mask read");
        wr(A_MASK, 8'h00);
        check("R8 mask after read break", 64'(pix_mask_o), 64'h00);
        check("R8 colour kept", 64'(colour_mode_o), 64'hC5);

        // R8 other-port write breaks the run
        mask_reads(2, 8'h00, "R8 mask read");
        wr(A_GFX_I, 8'h05);
        mask_reads(2, 8'h00, "R8 mask read");
        wr(A_MASK, 8'h81);
        check("R8 mask after write break", 64'(pix_mask_o), 64'h81);
        check("R8 colour kept 2", 64'(colour_mode_o), 64'hC5);

        repeat (3) @(negedge clk);
        check("scoreboard drained", 64'(q_exp.size()), 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule